// File: doc/BRIEF.md
# DMA Page Translation Map

This block converts transfer-relative addresses into physical memory addresses for a disk-channel DMA adapter. A transfer engine presents a 17-bit virtual byte address. The upper eight bits select one of 256 map entries. The lower nine bits are the offset within a 512-byte page, and they pass straight through. Each entry holds a valid flag and a 21-bit page frame number. The physical address is the frame number placed above the nine offset bits.

Software reaches the entries through a simple register port, one entry per access. It can rewrite them at any moment, including while a transfer is running. Every lookup that the engine strobes records the consulted entry in a read-only "last entry" register, and it does this whether or not the entry is valid. A lookup of an entry whose valid flag is clear fails and raises an invalid-map error. That error is abort-class, and the adapter's status logic consumes it to stop the transfer. An adapter init clears the last-entry register only. A power-up reset also clears every map entry.

Top module: `pgmap_top`

## Requirements
- R1: A register write stores only bit 31 (valid) and bits 20:0 (frame number) of the written word. All other bits of an entry, of `reg_rdata` and of `sel_entry` read as zero.
- R2: A register read with `reg_re` high at a clock edge presents the addressed entry on `reg_rdata` after that edge. With `reg_re` low, `reg_rdata` holds its value.
- R3: The lookup uses `lk_vaddr[16:9]` as the entry index. `lk_paddr` equals `{frame number, lk_vaddr[8:0]}`, combinationally in the same cycle.
- R4: `lk_valid` reflects bit 31 of the consulted entry. `lk_inv_err` is high exactly when `lk_req` is high and that bit is clear, in the same cycle.
- R5: At each clock edge where `lk_req` is high and `init_req` is low, `sel_entry` takes the consulted entry, in its masked 32-bit form, whether it is valid or invalid. With no lookup, `sel_entry` holds its value.
- R6: Register reads and writes of map entries never change `sel_entry`.
- R7: `init_req` high at a clock edge clears `sel_entry` and leaves every map entry unchanged. If a lookup falls in the same cycle, the init takes priority.
- R8: `rst_n` low at a clock edge clears every map entry, `reg_rdata` and `sel_entry`.
- R9: If a write and a lookup hit the same entry in the same cycle, the lookup outputs and the captured `sel_entry` show the old contents. The next lookup shows the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| init_req | input | 1 | Adapter init, clears the last-entry register |
| reg_we | input | 1 | Register-port write strobe |
| reg_re | input | 1 | Register-port read strobe |
| reg_idx | input | 8 | Entry index for register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| lk_req | input | 1 | Lookup strobe from the transfer engine |
| lk_vaddr | input | 17 | Transfer virtual byte address |
| lk_paddr | output | 30 | Translated physical byte address |
| lk_valid | output | 1 | Consulted entry is valid |
| lk_inv_err | output | 1 | Invalid-map error, abort-class |
| sel_entry | output | 32 | Last consulted entry, read-only |

## Verification
Two of this block's functions can fall in one cycle: a software write that rewrites an entry, and an engine lookup of that same entry. The bench drives both strobes in a single cycle on the same index. It judges the result in three places: the combinational lookup outputs in that cycle must show the old frame, `sel_entry` after the edge must hold the old entry, and a second lookup must show the new one. Init colliding with a lookup is provoked the same way, and `sel_entry` must read zero afterwards.

// File: rtl/pgmap_pkg.sv
// Package: shared constants and the map entry type for the page map.
// Assumes 512-byte pages and a 256-entry map; all widths derive from here.
package pgmap_pkg;
    localparam int IDX_W   = 8;
    localparam int OFS_W   = 9;
    localparam int PFN_W   = 21;
    localparam int WORD_W  = 32;
    localparam int VLD_POS = 31;
    localparam int VA_W    = IDX_W + OFS_W;
    localparam int PA_W    = PFN_W + OFS_W;
    localparam int N_ENT   = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic [PFN_W-1:0] pfn;
    } map_ent_t;

    // Expand a stored entry to its bus word; reserved bits are zero.
    function automatic logic [WORD_W-1:0] ent_to_word(map_ent_t e);
        logic [WORD_W-1:0] w;
        w              = '0;
        w[VLD_POS]     = e.vld;
        w[PFN_W-1:0]   = e.pfn;
        return w;
    endfunction

    // Keep only the valid bit and frame field of a bus word.
    function automatic map_ent_t word_to_ent(logic [WORD_W-1:0] w);
        map_ent_t e;
        e.vld = w[VLD_POS];
        e.pfn = w[PFN_W-1:0];
        return e;
    endfunction
endpackage

// File: rtl/pgmap_store.sv
// Module: entry storage with one write port and two combinational read ports.
// Assumes a write and a read of the same entry in one cycle returns the old
// value (write lands on the edge). Cleared only by the power-up reset.
module pgmap_store
    import pgmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  map_ent_t         wr_ent,
    input  logic [IDX_W-1:0] rda_idx,
    output map_ent_t         rda_ent,
    input  logic [IDX_W-1:0] rdb_idx,
    output map_ent_t         rdb_ent
);
    map_ent_t ent_q [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        // Hold one entry; clear on power-up, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                ent_q[g] <= wr_ent;
        end
    end

    // Register-port read and lookup-port read.
    assign rda_ent = ent_q[rda_idx];
    assign rdb_ent = ent_q[rdb_idx];
endmodule

// File: rtl/pgmap_xlate.sv
// Module: combinational address translation for one lookup.
// Assumes the entry has already been fetched by the index this module exposes.
module pgmap_xlate
    import pgmap_pkg::*;
(
    input  logic             lk_req,
    input  logic [VA_W-1:0]  vaddr,
    input  map_ent_t         ent,
    output logic [IDX_W-1:0] page_idx,
    output logic [PA_W-1:0]  paddr,
    output logic             hit,
    output logic             inv_err
);
    // Split the address, join frame and offset, flag invalid entries.
    always_comb begin
        page_idx = vaddr[VA_W-1:OFS_W];
        paddr    = {ent.pfn, vaddr[OFS_W-1:0]};
        hit      = ent.vld;
        inv_err  = lk_req && !ent.vld;
    end
endmodule

// File: rtl/pgmap_selreg.sv
// Module: last-consulted-entry register. Init takes priority over capture.
// Assumes capture data is the masked entry seen by the lookup this cycle.
module pgmap_selreg
    import pgmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              cap_en,
    input  map_ent_t          cap_ent,
    output logic [WORD_W-1:0] sel_word
);
    map_ent_t sel_q;

    // Clear on reset or init, else record the entry of a strobed lookup.
    always_ff @(posedge clk) begin
        if (!rst_n || init_req)
            sel_q <= '0;
        else if (cap_en)
            sel_q <= cap_ent;
    end

    assign sel_word = ent_to_word(sel_q);
endmodule

// File: rtl/pgmap_top.sv
// Module: page map top. Register port for entry access, lookup port for the
// transfer engine, last-entry register. Assumes single-beat register access.
module pgmap_top
    import pgmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_valid,
    output logic              lk_inv_err,
    output logic [WORD_W-1:0] sel_entry
);
    map_ent_t         rda_ent;
    map_ent_t         rdb_ent;
    logic [IDX_W-1:0] lk_idx;

    pgmap_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_idx  (reg_idx),
        .wr_ent  (word_to_ent(reg_wdata)),
        .rda_idx (reg_idx),
        .rda_ent (rda_ent),
        .rdb_idx (lk_idx),
        .rdb_ent (rdb_ent)
    );

    pgmap_xlate u_xlate (
        .lk_req   (lk_req),
        .vaddr    (lk_vaddr),
        .ent      (rdb_ent),
        .page_idx (lk_idx),
        .paddr    (lk_paddr),
        .hit      (lk_valid),
        .inv_err  (lk_inv_err)
    );

    pgmap_selreg u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_req (init_req),
        .cap_en   (lk_req),
        .cap_ent  (rdb_ent),
        .sel_word (sel_entry)
    );

    // Register-port read data, one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_re)
            reg_rdata <= ent_to_word(rda_ent);
    end
endmodule

// File: rtl/pgmap_chk.sv
// Module: property checker for pgmap_top, attached by bind below.
// Assumes the port-level behaviour stated in the requirements.
module pgmap_chk
    import pgmap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              init_req,
    input logic              reg_re,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              lk_req,
    input logic [OFS_W-1:0]  lk_ofs,
    input logic [PA_W-1:0]   lk_paddr,
    input logic              lk_valid,
    input logic              lk_inv_err,
    input logic [WORD_W-1:0] sel_entry
);
    localparam logic [WORD_W-1:0] KEEP = ent_to_word('1);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rdata & ~KEEP) == '0) && ((sel_entry & ~KEEP) == '0)); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata)); // R2
    AST_OFS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_paddr[OFS_W-1:0] == lk_ofs); // R3
    AST_ERR_WHEN: assert property (@(posedge clk) disable iff (!rst_n)
        lk_inv_err == (lk_req && !lk_valid)); // R4
    AST_SEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !init_req) |=> (sel_entry[VLD_POS] == $past(lk_valid)) &&
        (sel_entry[PFN_W-1:0] == $past(lk_paddr[PA_W-1:OFS_W]))); // R5
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_req && !init_req) |=> $stable(sel_entry)); // R6
    AST_INIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> (sel_entry == '0)); // R7
endmodule

bind pgmap_top pgmap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_req   (init_req),
    .reg_re     (reg_re),
    .reg_rdata  (reg_rdata),
    .lk_req     (lk_req),
    .lk_ofs     (lk_vaddr[pgmap_pkg::OFS_W-1:0]),
    .lk_paddr   (lk_paddr),
    .lk_valid   (lk_valid),
    .lk_inv_err (lk_inv_err),
    .sel_entry  (sel_entry)
);

// File: tb/sim_pgmap_top.sv
module sim_pgmap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [7:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_req = 1'b0;
    logic [16:0] lk_vaddr = '0;
    logic [29:0] lk_paddr;
    logic        lk_valid;
    logic        lk_inv_err;
    logic [31:0] sel_entry;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [31:0] KEEP = 32'h801F_FFFF;
    // {index, written word, page offset used for lookup}
    localparam int NV = 8;
    localparam logic [48:0] VEC [NV] = '{
        {8'h00, 32'hFFFF_FFFF, 9'h000},
        {8'h01, 32'h8000_0123, 9'h1FF},
        {8'h7F, 32'h7FE0_0ABC, 9'h055},
        {8'h80, 32'h8015_5555, 9'h100},
        {8'hFF, 32'h8010_0000, 9'h001},
        {8'h10, 32'h0000_0000, 9'h0AA},
        {8'h42, 32'hC0A0_0001, 9'h123},
        {8'h03, 32'h801A_BCDE, 9'h07F}
    };

    always #2 clk = ~clk;

    pgmap_top u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] i, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] i, output logic [31:0] d);
        @(negedge clk); reg_re = 1'b1; reg_idx = i;
        @(negedge clk); reg_re = 1'b0; d = reg_rdata;
    endtask

    // Strobe one lookup; returns combinational outputs seen in that cycle.
    task automatic look(input logic [16:0] va, output logic [29:0] pa,
                        output logic v, output logic e);
        @(negedge clk); lk_req = 1'b1; lk_vaddr = va;
        #1; pa = lk_paddr; v = lk_valid; e = lk_inv_err;
        @(negedge clk); lk_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, ex, s0;
        logic [29:0] pa;
        logic        v, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 rdata", reg_rdata, 32'h0);
        chk("R8 sel", sel_entry, 32'h0);
        rd(8'h05, d); chk("R8 entry", d, 32'h0);

        // R1/R2 table: write all, read back masked
        for (int k = 0; k < NV; k++) wr(VEC[k][48:41], VEC[k][40:9]);
        for (int k = 0; k < NV; k++) begin
            rd(VEC[k][48:41], d);
            chk("R1 R2 readback", d, VEC[k][40:9] & KEEP);
        end
        // R3/R4/R5 table: lookup each entry
        for (int k = 0; k < NV; k++) begin
            ex = VEC[k][40:9] & KEEP;
            look({VEC[k][48:41], VEC[k][8:0]}, pa, v, e);
            chk("R3 paddr", {2'b0, pa}, {2'b0, ex[20:0], VEC[k][8:0]});
            chk("R4 valid", {31'b0, v}, {31'b0, ex[31]});
            chk("R4 err", {31'b0, e}, {31'b0, ~ex[31]});
            chk("R5 sel", sel_entry, ex);
        end

        // R4: no error without a strobe, even on an invalid entry
        @(negedge clk); lk_vaddr = {8'h7F, 9'h0}; #1;
        chk("R4 no strobe", {31'b0, lk_inv_err}, 32'h0);

        // R5 hold / R2 hold
        s0 = sel_entry;
        repeat (3) @(negedge clk);
        chk("R5 hold", sel_entry, s0);
        chk("R2 hold", reg_rdata, VEC[NV-1][40:9] & KEEP);

        // R6: register accesses leave sel_entry alone
        look({8'h80, 9'h0}, pa, v, e);
        rd(8'h01, d); wr(8'h80, 32'h8000_0042);
        chk("R6 sel", sel_entry, 32'h8015_5555);

        // R9: write and lookup same entry same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 8'h03; reg_wdata = 32'h8000_0777;
        lk_req = 1'b1; lk_vaddr = {8'h03, 9'h011};
        #1; pa = lk_paddr;
        @(negedge clk); reg_we = 1'b0; lk_req = 1'b0;
        chk("R9 old paddr", {2'b0, pa}, {2'b0, 21'h1ABCDE, 9'h011});
        chk("R9 old sel", sel_entry, 32'h801A_BCDE);
        look({8'h03, 9'h011}, pa, v, e);
        chk("R9 new paddr", {2'b0, pa}, {2'b0, 21'h000777, 9'h011});

        // R7: init clears sel, map intact; init beats lookup
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
        chk("R7 sel clr", sel_entry, 32'h0);
        rd(8'h03, d); chk("R7 map kept", d, 32'h8000_0777);
        @(negedge clk); init_req = 1'b1; lk_req = 1'b1; lk_vaddr = {8'h01, 9'h0};
        @(negedge clk); init_req = 1'b0; lk_req = 1'b0;
        chk("R7 priority", sel_entry, 32'h0);

        // R8: power-up reset mid-run clears entries
        look({8'h01, 9'h0}, pa, v, e);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R8 sel rst", sel_entry, 32'h0);
        rd(8'h01, d); chk("R8 entry rst", d, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule